// File: doc/BRIEF.md
# Pin-Driven Power-Down Freeze Controller

This block sits between a core logic region and its I/O pins. When the feature is enabled and the external power-down pin goes high, the controller freezes the boundary. It captures every output data bit and every output enable, and it holds the core's registers by dropping the core clock-enable. It also replaces every input the core sees with the last value sampled before the freeze. When the pin falls, the boundary stays frozen for a fixed recovery window, counted in clock cycles. After that window, outputs, enables, inputs and the core clock are all released in the same cycle.

The power-down pin is synchronised through two flops before it reaches the state machine. While the feature is enabled, the pin is never passed to the core as a logic input. When the feature is disabled, the synchronised pin is passed to the core as an ordinary input, and the boundary passes everything straight through. All data paths are plain parallel pin vectors, sampled every cycle. There is no valid/ready handshake and no back-pressure, because pins cannot stall.

Top module: `pd_freeze_ctrl`

## Requirements
- R1: With `cfg_pd_en` low, `pin_out_data`, `pin_out_oe` and `core_in` follow their live sources combinationally and `core_clk_en` stays high, whatever `pd_pin` does; dropping `cfg_pd_en` returns the controller to the running state on the next edge.
- R2: With the feature enabled, `pd_pin` is sampled through two flops, so the freeze takes effect after the third rising edge following the rise of `pd_pin`, and not before.
- R3: While frozen, `pin_out_data` holds the value that `core_out_data` had at the freezing edge, regardless of later changes.
- R4: While frozen, `pin_out_oe` holds the enable vector captured at the freezing edge (bit value 1 = driven, 0 = tri-stated), so a tri-stated pin stays tri-stated.
- R5: While frozen, `core_in` holds the value `pin_in` had at the freezing edge; later input changes do not reach the core.
- R6: `core_clk_en` is low in both the frozen and the recovery states and high in the running state.
- R7: After `pd_pin` falls, the boundary stays frozen for exactly 2 + RECOVER_CYCLES cycles: 2 for synchronisation, then RECOVER_CYCLES of recovery. It is then released, and outputs and `core_in` follow their live sources again.
- R8: If `pd_pin` is asserted again during recovery, the controller goes back to the frozen state without releasing any held value, and a full recovery window is needed after the next fall.
- R9: `core_pd_in` is 0 whenever `cfg_pd_en` is high; when `cfg_pd_en` is low it carries the two-flop synchronised `pd_pin`.
- R10: After reset the controller is running: `core_clk_en` is high and all paths pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pd_en | input | 1 | Enables the power-down freeze feature |
| pd_pin | input | 1 | Asynchronous power-down pin |
| core_out_data | input | OUT_W | Output data from the core |
| core_out_oe | input | OUT_W | Output enables from the core (1 = drive) |
| pin_out_data | output | OUT_W | Output data toward the pads |
| pin_out_oe | output | OUT_W | Output enables toward the pads |
| pin_in | input | IN_W | Input values from the pads |
| core_in | output | IN_W | Inputs delivered to the core |
| core_clk_en | output | 1 | Clock-enable for the core's registers |
| core_pd_in | output | 1 | Power-down pin as a logic input (only when feature disabled) |

## Verification
Assertions check on every cycle that held outputs do not move while frozen, and that re-assertion during recovery sends the state machine back to the frozen state. They also check that disabling the feature forces the running state, and that the recovery counter stays within its range. The exact latency of the freeze, the exact length of the recovery window, and the values captured on each path can only be shown by the bench scenarios. In those scenarios, inputs change after the freeze, and the bench observes at the pins that nothing leaks through until the computed release cycle.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_FROZEN  = 2'd1,
    ST_RECOVER = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
  import pd_pkg::*;
#(
  parameter int RECOVER_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic pd_i,
  output logic freeze_o
);
  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVER_CYCLES - 1);

  pd_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_RUN:    if (pd_i) state_d = ST_FROZEN;
        ST_FROZEN: if (!pd_i) begin
          state_d = ST_RECOVER;
          cnt_d   = CNT_LOAD;
        end
        ST_RECOVER: begin
          if (pd_i) begin
            state_d = ST_FROZEN;
            cnt_d   = '0;
          end else if (cnt_q == '0) begin
            state_d = ST_RUN;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign freeze_o = (state_q != ST_RUN);

  // R8
  reassert_refreeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECOVER && pd_i && en_i) |=> (state_q == ST_FROZEN));

  // R1
  disable_forces_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (state_q == ST_RUN));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);

  // R2
  no_spurious_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !pd_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/pd_hold.sv
module pd_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (!freeze_i) hold_q <= live_i;
  end

  assign out_o = freeze_i ? hold_q : live_i;

  // R3 R4 R5
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> (!freeze_i || $stable(out_o)));
endmodule

// File: rtl/pd_freeze_ctrl.sv
module pd_freeze_ctrl #(
  parameter int OUT_W          = 16,
  parameter int IN_W           = 16,
  parameter int RECOVER_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pd_en,
  input  logic             pd_pin,
  input  logic [OUT_W-1:0] core_out_data,
  input  logic [OUT_W-1:0] core_out_oe,
  output logic [OUT_W-1:0] pin_out_data,
  output logic [OUT_W-1:0] pin_out_oe,
  input  logic [IN_W-1:0]  pin_in,
  output logic [IN_W-1:0]  core_in,
  output logic             core_clk_en,
  output logic             core_pd_in
);
  logic pd_s;
  logic freeze;

  pd_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(pd_pin),
    .sync_o (pd_s)
  );

  pd_fsm #(.RECOVER_CYCLES(RECOVER_CYCLES)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_pd_en),
    .pd_i    (pd_s),
    .freeze_o(freeze)
  );

  pd_hold #(.W(OUT_W)) u_hold_data (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze),
    .live_i(core_out_data), .out_o(pin_out_data)
  );

  pd_hold #(.W(OUT_W)) u_hold_oe (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze),
    .live_i(core_out_oe), .out_o(pin_out_oe)
  );

  pd_hold #(.W(IN_W)) u_hold_in (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze),
    .live_i(pin_in), .out_o(core_in)
  );

  assign core_clk_en = ~freeze;
  assign core_pd_in  = cfg_pd_en ? 1'b0 : pd_s;

  // R6
  clk_en_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_clk_en |-> (pin_out_data == core_out_data && core_in == pin_in));

  // R9
  pd_not_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pd_en |-> !core_pd_in);
endmodule

// File: tb/test_pd_freeze_ctrl.sv
module test_pd_freeze_ctrl;
  localparam int W = 3;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_pd_en = 1'b1;
  logic pd_pin = 1'b0;
  logic [W-1:0] core_out_data = '0, core_out_oe = '0, pin_in = '0;
  logic [W-1:0] pin_out_data, pin_out_oe, core_in;
  logic core_clk_en, core_pd_in;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pd_freeze_ctrl #(.OUT_W(W), .IN_W(W), .RECOVER_CYCLES(N)) i_pd_freeze_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .pd_pin(pd_pin),
    .core_out_data(core_out_data), .core_out_oe(core_out_oe),
    .pin_out_data(pin_out_data), .pin_out_oe(pin_out_oe),
    .pin_in(pin_in), .core_in(core_in),
    .core_clk_en(core_clk_en), .core_pd_in(core_pd_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_held(input string req, input logic [W-1:0] d,
                          input logic [W-1:0] oe, input logic [W-1:0] in);
    #1;
    chk(pin_out_data == d, {req, " data"}, pin_out_data, d);
    chk(pin_out_oe == oe, {req, " oe"}, pin_out_oe, oe);
    chk(core_in == in, {req, " in"}, core_in, in);
  endtask

  task automatic release_and_count(input string req, input logic [W-1:0] d);
    int low = 0;
    pd_pin = 1'b0;
    for (int k = 0; k < 100; k++) begin
      step(1);
      #1;
      if (core_clk_en) break;
      low++;
      if (pin_out_data != d) chk(0, {req, " held during recover"}, pin_out_data, d);
    end
    chk(low == 2 + N, {req, " recover length"}, low, 2 + N);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    core_out_data = 3'd5; core_out_oe = 3'd2; pin_in = 3'd6;
    #1;
    // R10 reset state
    chk(core_clk_en == 1'b1, "R10 clk_en", core_clk_en, 1);
    chk(core_pd_in == 1'b0, "R10 pd_in", core_pd_in, 0);
    chk_held("R10 passthrough", 3'd5, 3'd2, 3'd6);

    // R1 feature disabled: pin has no freeze effect; R9 pin routed as logic input
    step(1);
    cfg_pd_en = 1'b0;
    pd_pin = 1'b1;
    step(4);
    chk(core_pd_in == 1'b1, "R9 pd_in when disabled", core_pd_in, 1);
    for (int v = 0; v < 8; v++) begin
      core_out_data = W'(v); core_out_oe = W'(v) ^ 3'd7; pin_in = W'(v);
      #1;
      chk(core_clk_en == 1'b1, "R1 clk_en", core_clk_en, 1);
      chk_held("R1 passthrough", W'(v), W'(v) ^ 3'd7, W'(v));
      step(1);
    end
    pd_pin = 1'b0;
    step(3);
    cfg_pd_en = 1'b1;
    step(1);

    // R2..R7 sweep over all capture patterns
    for (int p = 0; p < 8; p++) begin
      logic [W-1:0] d, oe, in;
      d = W'(p); oe = ~W'(p); in = W'(p) ^ 3'd5;
      core_out_data = d; core_out_oe = oe; pin_in = in;
      pd_pin = 1'b1;
      step(2);
      #1;
      chk(core_clk_en == 1'b1, "R2 not yet frozen", core_clk_en, 1);
      step(1);
      #1;
      chk(core_clk_en == 1'b0, "R6 frozen clk_en", core_clk_en, 0);
      chk(core_pd_in == 1'b0, "R9 pd_in enabled", core_pd_in, 0);
      core_out_data = ~d; core_out_oe = ~oe; pin_in = ~in;
      step(3);
      chk_held("R3 R4 R5 held", d, oe, in);
      release_and_count("R7", d);
      chk_held("R7 released", ~d, ~oe, ~in);
      step(1);
    end

    // R8 reassert during recovery
    core_out_data = 3'd3; core_out_oe = 3'd4; pin_in = 3'd1;
    pd_pin = 1'b1;
    step(3);
    core_out_data = 3'd6; core_out_oe = 3'd1; pin_in = 3'd2;
    step(2);
    pd_pin = 1'b0;
    step(4);
    pd_pin = 1'b1;
    step(N + 6);
    #1;
    chk(core_clk_en == 1'b0, "R8 still frozen", core_clk_en, 0);
    chk_held("R8 held", 3'd3, 3'd4, 3'd1);
    release_and_count("R8", 3'd3);
    chk_held("R8 released", 3'd6, 3'd1, 3'd2);

    // R1 dropping the enable mid-freeze releases at once
    step(1);
    pd_pin = 1'b1;
    step(4);
    cfg_pd_en = 1'b0;
    step(1);
    #1;
    chk(core_clk_en == 1'b1, "R1 disable releases", core_clk_en, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule